// File: doc/BRIEF.md
# Repeat-Until-Stop Block Transfer Engine

This engine sits above a sequencer that performs one backplane cycle at a time. The engine issues the same command over and over: a station, a subaddress and a function code, all captured when the block starts. Each repetition moves one data word. Read words leave the engine on a valid/ready stream. Write words arrive on a second valid/ready stream and are placed on the backplane write data for their cycle.

The block's length is set by the data, not fixed in advance. There are two termination modes:
- In Q-stop mode, the first cycle whose Q response is 0 ends the block.
- In stop-word mode, a word equal to a programmed pattern ends the block.

A hard word limit applies in both modes. An X=0 (no acknowledge) response aborts the block on any cycle. When the block ends, the engine gives a one-cycle done pulse carrying the word count and a 2-bit reason code.

Top module: `rpt_xfer_engine`

## Requirements
- R1: On a start pulse in idle, station, subaddress, function, direction, mode, pattern and forward bit are captured. Every backplane cycle of that block presents the captured station, subaddress and function. A start pulse while busy has no effect on the running block.
- R2: Q-stop mode (cfg_mode=0). The block ends on the first acknowledged cycle with bp_q=0, with done_reason=0. That cycle's word is neither forwarded nor counted.
- R3: Stop-word mode (cfg_mode=1), read direction. A read word equal to cfg_stop_pat ends the block with done_reason=1. That word is forwarded and counted only when cfg_fwd_stop=1. bp_q is ignored in this mode.
- R4: Write direction (cfg_write=1). Each cycle takes exactly one word from the write stream and presents it on bp_wdata. In stop-word mode, the written word is compared with the pattern; a matching word is written and counted, and then done_reason=1.
- R5: After MAX_WORDS counted words, the block ends with done_reason=2. A stop-word match on that final word reports done_reason=1 instead.
- R6: An acknowledged cycle with bp_x=0 aborts the block with done_reason=3. It takes priority over every other termination, and done_count holds only the words completed before it.
- R7: While a read word waits on the output stream, no backplane cycle is requested. rd_valid and rd_data stay stable until rd_ready.
- R8: bp_req, once raised, stays high with a stable command and write data until bp_ack.
- R9: done is a single-cycle pulse carrying done_reason and done_count. busy is low in the cycle after it.
- R10: After reset, busy, done, bp_req, rd_valid and wr_ready are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a block (taken only in idle) |
| cfg_stn | input | STN_W | Station of the repeated command |
| cfg_sub | input | SUB_W | Subaddress of the repeated command |
| cfg_fn | input | FN_W | Function code of the repeated command |
| cfg_write | input | 1 | 1 = write direction, 0 = read |
| cfg_mode | input | 1 | 0 = Q-stop, 1 = stop-word |
| cfg_stop_pat | input | DW | Terminating data pattern |
| cfg_fwd_stop | input | 1 | Forward and count a matching read word |
| bp_req | output | 1 | Request one backplane cycle |
| bp_stn | output | STN_W | Station presented to the sequencer |
| bp_sub | output | SUB_W | Subaddress presented to the sequencer |
| bp_fn | output | FN_W | Function presented to the sequencer |
| bp_wdata | output | DW | Write data for the cycle |
| bp_ack | input | 1 | Cycle complete; bp_q, bp_x and bp_rdata valid |
| bp_q | input | 1 | Q response of the cycle |
| bp_x | input | 1 | X response of the cycle |
| bp_rdata | input | DW | Read data of the cycle |
| rd_valid | output | 1 | Read word available |
| rd_ready | input | 1 | Read stream sink ready |
| rd_data | output | DW | Read word |
| wr_valid | input | 1 | Write word available |
| wr_ready | output | 1 | Engine takes a write word |
| wr_data | input | DW | Write word |
| busy | output | 1 | Block in progress |
| done | output | 1 | Block finished (one cycle) |
| done_reason | output | 2 | 0 Q-stop, 1 stop word, 2 length cap, 3 no-acknowledge |
| done_count | output | CW | Words counted in the block |

## Verification
The bench builds the engine with MAX_WORDS=8 and 16-bit data. This puts the length cap within a few cycles, so the bench can drive a cap ending in both modes, and a stop-word match that lands exactly on the eighth word. The bench models the module behind the sequencer. That model returns an incrementing data sequence and can drop Q or X on a chosen cycle, which brings a zero-word block, a no-acknowledge abort on a matching word, and Q being ignored in stop-word mode within reach. A stalled read stream and a start pulse in mid-block are driven as directed cases.

// File: rtl/rpt_xfer_engine.sv
module rpt_xfer_engine #(
  parameter int DW        = 24,
  parameter int STN_W     = 5,
  parameter int SUB_W     = 5,
  parameter int FN_W      = 5,
  parameter int MAX_WORDS = 16384,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [STN_W-1:0] cfg_stn,
  input  logic [SUB_W-1:0] cfg_sub,
  input  logic [FN_W-1:0]  cfg_fn,
  input  logic             cfg_write,
  input  logic             cfg_mode,
  input  logic [DW-1:0]    cfg_stop_pat,
  input  logic             cfg_fwd_stop,
  output logic             bp_req,
  output logic [STN_W-1:0] bp_stn,
  output logic [SUB_W-1:0] bp_sub,
  output logic [FN_W-1:0]  bp_fn,
  output logic [DW-1:0]    bp_wdata,
  input  logic             bp_ack,
  input  logic             bp_q,
  input  logic             bp_x,
  input  logic [DW-1:0]    bp_rdata,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [DW-1:0]    rd_data,
  input  logic             wr_valid,
  output logic             wr_ready,
  input  logic [DW-1:0]    wr_data,
  output logic             busy,
  output logic             done,
  output logic [1:0]       done_reason,
  output logic [CW-1:0]    done_count
);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CYC, S_OUT, S_DONE} st_t;

  st_t              st;
  logic [STN_W-1:0] stn_q;
  logic [SUB_W-1:0] sub_q;
  logic [FN_W-1:0]  fn_q;
  logic             wr_q, sw_q, fwd_q, last_q;
  logic [DW-1:0]    pat_q, dbuf;
  logic [CW-1:0]    cnt;
  logic [1:0]       rsn;

  wire [DW-1:0] cmp_word = wr_q ? dbuf : bp_rdata;
  wire          hit      = sw_q && (cmp_word == pat_q);
  wire          at_cap   = (cnt == CW'(MAX_WORDS - 1));
  wire          take     = (st == S_CYC) && bp_ack;

  assign bp_req      = (st == S_CYC);
  assign bp_stn      = stn_q;
  assign bp_sub      = sub_q;
  assign bp_fn       = fn_q;
  assign bp_wdata    = dbuf;
  assign rd_valid    = (st == S_OUT);
  assign rd_data     = dbuf;
  assign wr_ready    = (st == S_FETCH);
  assign busy        = (st != S_IDLE);
  assign done        = (st == S_DONE);
  assign done_reason = rsn;
  assign done_count  = cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      stn_q  <= '0;
      sub_q  <= '0;
      fn_q   <= '0;
      wr_q   <= 1'b0;
      sw_q   <= 1'b0;
      fwd_q  <= 1'b0;
      last_q <= 1'b0;
      pat_q  <= '0;
      dbuf   <= '0;
      cnt    <= '0;
      rsn    <= 2'd0;
    end else begin
      case (st)
        S_IDLE: if (start) begin
          stn_q  <= cfg_stn;
          sub_q  <= cfg_sub;
          fn_q   <= cfg_fn;
          wr_q   <= cfg_write;
          sw_q   <= cfg_mode;
          pat_q  <= cfg_stop_pat;
          fwd_q  <= cfg_fwd_stop;
          cnt    <= '0;
          last_q <= 1'b0;
          st     <= cfg_write ? S_FETCH : S_CYC;
        end
        S_FETCH: if (wr_valid) begin
          dbuf <= wr_data;
          st   <= S_CYC;
        end
        S_CYC: if (take) begin
          if (!bp_x) begin
            rsn <= 2'd3;
            st  <= S_DONE;
          end else if (!sw_q && !bp_q) begin
            rsn <= 2'd0;
            st  <= S_DONE;
          end else if (hit) begin
            rsn <= 2'd1;
            if (wr_q) begin
              cnt <= cnt + 1'b1;
              st  <= S_DONE;
            end else if (fwd_q) begin
              cnt    <= cnt + 1'b1;
              dbuf   <= bp_rdata;
              last_q <= 1'b1;
              st     <= S_OUT;
            end else begin
              st <= S_DONE;
            end
          end else begin
            cnt <= cnt + 1'b1;
            if (at_cap) begin
              rsn    <= 2'd2;
              last_q <= 1'b1;
            end
            if (wr_q) st <= at_cap ? S_DONE : S_FETCH;
            else begin
              dbuf <= bp_rdata;
              st   <= S_OUT;
            end
          end
        end
        S_OUT: if (rd_ready) st <= last_q ? S_DONE : S_CYC;
        S_DONE: st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rpt_xfer_engine_chk.sv
module rpt_xfer_engine_chk #(
  parameter int DW        = 24,
  parameter int STN_W     = 5,
  parameter int SUB_W     = 5,
  parameter int FN_W      = 5,
  parameter int MAX_WORDS = 16384,
  localparam int CW       = $clog2(MAX_WORDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bp_req,
  input logic [STN_W-1:0] bp_stn,
  input logic [SUB_W-1:0] bp_sub,
  input logic [FN_W-1:0]  bp_fn,
  input logic [DW-1:0]    bp_wdata,
  input logic             bp_ack,
  input logic             bp_x,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [DW-1:0]    rd_data,
  input logic             busy,
  input logic             done,
  input logic [1:0]       done_reason,
  input logic [CW-1:0]    done_count
);

  AST_CMD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(bp_stn) && $stable(bp_sub) && $stable(bp_fn)); // R1

  AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> done_count <= CW'(MAX_WORDS)); // R5

  AST_NOACK_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && bp_ack && !bp_x |=> done && done_reason == 2'd3); // R6

  AST_NO_CYC_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !bp_req); // R7

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    bp_req && !bp_ack |=> bp_req && $stable(bp_wdata) && $stable(bp_stn)); // R8

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && !busy); // R9

endmodule

bind rpt_xfer_engine rpt_xfer_engine_chk #(
  .DW(DW), .STN_W(STN_W), .SUB_W(SUB_W), .FN_W(FN_W), .MAX_WORDS(MAX_WORDS)
) u_chk (.*);

// File: tb/rpt_xfer_engine_tb.sv
module rpt_xfer_engine_tb;

  localparam int DW  = 16;
  localparam int MW  = 8;
  localparam int CW  = $clog2(MW + 1);

  typedef struct packed {
    logic        wr;
    logic        sw;
    logic        fwd;
    logic [15:0] pat;
    logic [3:0]  qat;
    logic [3:0]  xat;
    logic [1:0]  rsn;
    logic [3:0]  cnt;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 1'b0, 16'h0000, 4'd3,  4'd15, 2'd0, 4'd3},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 4'd0,  4'd15, 2'd0, 4'd0},
    '{1'b0, 1'b1, 1'b1, 16'h0104, 4'd15, 4'd15, 2'd1, 4'd5},
    '{1'b0, 1'b1, 1'b0, 16'h0104, 4'd15, 4'd15, 2'd1, 4'd4},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 4'd15, 4'd15, 2'd2, 4'd8},
    '{1'b0, 1'b1, 1'b0, 16'h01FF, 4'd2,  4'd15, 2'd2, 4'd8},
    '{1'b0, 1'b0, 1'b0, 16'h0000, 4'd15, 4'd2,  2'd3, 4'd2},
    '{1'b0, 1'b1, 1'b1, 16'h0107, 4'd15, 4'd15, 2'd1, 4'd8},
    '{1'b1, 1'b0, 1'b0, 16'h0000, 4'd4,  4'd15, 2'd0, 4'd4},
    '{1'b1, 1'b1, 1'b0, 16'h0202, 4'd15, 4'd15, 2'd1, 4'd3},
    '{1'b1, 1'b0, 1'b0, 16'h0000, 4'd15, 4'd0,  2'd3, 4'd0},
    '{1'b0, 1'b1, 1'b1, 16'h0103, 4'd15, 4'd3,  2'd3, 4'd3}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [4:0]    cfg_stn = '0, cfg_sub = '0, cfg_fn = '0;
  logic          cfg_write = 1'b0, cfg_mode = 1'b0, cfg_fwd_stop = 1'b0;
  logic [DW-1:0] cfg_stop_pat = '0;
  logic          bp_req;
  logic [4:0]    bp_stn, bp_sub, bp_fn;
  logic [DW-1:0] bp_wdata;
  logic          bp_ack = 1'b0, bp_q = 1'b1, bp_x = 1'b1;
  logic [DW-1:0] bp_rdata = '0;
  logic          rd_valid;
  logic          rd_ready = 1'b1;
  logic [DW-1:0] rd_data;
  logic          wr_valid = 1'b1;
  logic          wr_ready;
  logic [DW-1:0] wr_data = '0;
  logic          busy, done;
  logic [1:0]    done_reason;
  logic [CW-1:0] done_count;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  rpt_xfer_engine #(.DW(DW), .STN_W(5), .SUB_W(5), .FN_W(5), .MAX_WORDS(MW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_stn(cfg_stn), .cfg_sub(cfg_sub), .cfg_fn(cfg_fn),
    .cfg_write(cfg_write), .cfg_mode(cfg_mode), .cfg_stop_pat(cfg_stop_pat),
    .cfg_fwd_stop(cfg_fwd_stop),
    .bp_req(bp_req), .bp_stn(bp_stn), .bp_sub(bp_sub), .bp_fn(bp_fn),
    .bp_wdata(bp_wdata), .bp_ack(bp_ack), .bp_q(bp_q), .bp_x(bp_x),
    .bp_rdata(bp_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .busy(busy), .done(done), .done_reason(done_reason), .done_count(done_count)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic run_vec(input int vi, input bit stall, input bit restart);
    vec_t v = VECS[vi];
    int k = 0, ridx = 0, widx = 0, scnt = 0, cyc = 0;
    bit fin = 0;
    logic [1:0] got_r = '0;
    int got_c = 0;
    @(negedge clk);
    cfg_stn = 5'd9; cfg_sub = 5'd2; cfg_fn = 5'd16;
    cfg_write = v.wr; cfg_mode = v.sw; cfg_fwd_stop = v.fwd; cfg_stop_pat = v.pat;
    start = 1'b1;
    while (!fin && cyc < 300) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      if (restart && cyc == 4) begin
        cfg_stn = 5'd3; cfg_sub = 5'd7; cfg_fn = 5'd1; cfg_write = 1'b1; cfg_mode = 1'b1;
        start = 1'b1;
      end
      if (done) begin
        got_r = done_reason;
        got_c = int'(done_count);
        fin = 1;
        bp_ack = 1'b0;
      end else begin
        if (bp_req && !bp_ack) begin
          chk(bp_stn == 5'd9 && bp_sub == 5'd2 && bp_fn == 5'd16, "R1 command fields",
              {bp_stn, bp_sub, bp_fn}, {5'd9, 5'd2, 5'd16});
          if (v.wr)
            chk(bp_wdata == DW'(16'h0200 + k), "R4 write data", bp_wdata, 16'h0200 + k);
          bp_q = (k != int'(v.qat));
          bp_x = (k != int'(v.xat));
          bp_rdata = DW'(16'h0100 + k);
          bp_ack = 1'b1;
          k++;
        end else begin
          bp_ack = 1'b0;
        end
        if (stall) begin
          if (rd_valid) scnt++; else scnt = 0;
          rd_ready = (scnt >= 4);
          if (rd_valid) chk(!bp_req, "R7 no cycle while word pending", bp_req, 0);
        end else begin
          rd_ready = 1'b1;
        end
        if (rd_valid && rd_ready) begin
          chk(rd_data == DW'(16'h0100 + ridx), "R7 read word order", rd_data, 16'h0100 + ridx);
          ridx++;
        end
        wr_data = DW'(16'h0200 + widx);
        if (wr_ready) widx++;
      end
    end
    chk(fin, "R9 block finished", fin, 1);
    chk(got_r == v.rsn, $sformatf("R2/R3/R5/R6 reason v%0d", vi), got_r, v.rsn);
    chk(got_c == int'(v.cnt), $sformatf("R2 R3 R4 R5 R6 count v%0d", vi), got_c, v.cnt);
    if (!v.wr)
      chk(ridx == int'(v.cnt), $sformatf("R3 words forwarded v%0d", vi), ridx, v.cnt);
    @(negedge clk);
    chk(!busy && !done, "R9 idle after done pulse", {busy, done}, 0);
    rd_ready = 1'b1;
    start = 1'b0;
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && !bp_req && !rd_valid && !wr_ready, "R10 reset state",
        {busy, done, bp_req, rd_valid, wr_ready}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !bp_req, "R10 idle after reset", {busy, bp_req}, 0);

    for (int i = 0; i < NV; i++) run_vec(i, 1'b0, 1'b0);

    // R7: read stream held off while words wait
    run_vec(2, 1'b1, 1'b0);
    // R1: start pulse with a different command in mid-block is ignored
    run_vec(0, 1'b0, 1'b1);

    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule